// File: doc/BRIEF.md
# Byte-Length Addressed Serial Register Loader

This block is the serial control port of a frequency synthesizer. An external controller sends a transfer made of a data line, a serial clock and an active-low frame enable, in the usual SPI or MICROWIRE way. The transfer carries no address field. The loader counts the bits that arrive while the enable is low. When the enable rises, it picks the destination from that count alone: one byte goes to the configuration register, two bytes go to the reference divider, and three bytes go to the combined main/swallow divider word. Any other length is dropped.

The two divider values are double-buffered. A reference write is only staged and has no visible effect. It becomes visible in the same clock cycle as the next divider-word commit, so that the reference and the main/swallow ratios change together. A commit waits while the counter logic reports that a counter is reloading. This keeps a counter from being loaded with a half-updated value.

The top configuration bit can turn the general-purpose output into a cascade data output. In that mode the output carries the bit that falls out of the 24-bit shift path, so several devices can be chained on one data line. The serial pins are taken into the system clock domain through two-flop synchronizers. The serial clock must therefore be slow compared with the system clock.

Top module: `serial_len_loader`

## Requirements
- R1: After a synchronous reset, `cfg_o`, `ref_o`, `div_o` and `dout` are all zero.
- R2: Data is taken MSB first on each rising `sclk` while `sen_n` is low. A frame of exactly 8 bits writes the configuration register `cfg_o` with those bits.
- R3: A frame of exactly 16 bits only stages a reference value. `ref_o` changes only in the cycle in which a divider-word commit happens.
- R4: A frame of exactly 24 bits stages a divider word. When no load is busy, the word appears on `div_o`, and any staged reference value appears on `ref_o` in the same cycle.
- R5: A pending commit is held while `div_load` or `ref_load` is high. It takes effect at the first clock edge at which both are low, so the new values are visible one clock after both go low.
- R6: A frame of zero bits, a frame whose length is not a multiple of 8, or a frame longer than 24 bits leaves `cfg_o`, `ref_o` and `div_o` unchanged.
- R7: Rising `sclk` edges while `sen_n` is high shift nothing into the serial path.
- R8: With `cfg_o[7]`=1, `dout` carries the bit shifted in 24 serial clocks earlier, updated on each shift. With `cfg_o[7]`=0, `dout` follows `cfg_o[6]`.
- R9: A divider-word commit with no staged reference value leaves `ref_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| sdin | input | 1 | Serial data, MSB first |
| sen_n | input | 1 | Active-low frame enable; its rising edge ends a frame |
| div_load | input | 1 | Main/swallow counters are reloading; holds commits |
| ref_load | input | 1 | Reference counter is reloading; holds commits |
| cfg_o | output | 8 | Configuration register |
| ref_o | output | 16 | Active reference divide ratio |
| div_o | output | 24 | Active main/swallow divider word |
| dout | output | 1 | General-purpose level or cascade data out |

## Verification
A wrong bit count or a wrong length decode sends a frame to the wrong register. That shows up on `cfg_o`, `ref_o` or `div_o` within about six system clocks after `sen_n` rises. A stuck pending flag shows up in one of two ways: `ref_o` fails to move on the next divider commit, or it moves one commit too early. A commit that ignores a busy load changes `div_o` one clock after the corrupted edge, while the load is still high. A shift-path fault (stray shifts while idle, a wrong depth) only appears on `dout` in cascade mode, and only when the affected bit reaches the 24th position.

// File: rtl/sl_pkg.sv
package sl_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CFG  = 2'd1,
    TGT_REF  = 2'd2,
    TGT_DIV  = 2'd3
  } tgt_e;

  // Destination chosen purely from the whole-byte length of a frame.
  function automatic tgt_e pick_target(input int nbytes, input int cfg_b,
                                       input int ref_b, input int div_b);
    if (nbytes == 0)          return TGT_NONE;
    else if (nbytes == cfg_b) return TGT_CFG;
    else if (nbytes == ref_b) return TGT_REF;
    else if (nbytes == div_b) return TGT_DIV;
    else                      return TGT_NONE;
  endfunction

endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RST_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 3,
  localparam int MAX_BITS = BYTE_W * MAX_BYTES,
  localparam int CNT_W    = $clog2(MAX_BITS + 1) + 1,
  localparam int BC_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_s,
  input  logic                din_s,
  input  logic                en_n_s,
  output logic                frame_done_q,
  output logic [BC_W-1:0]     frame_bytes_q,
  output logic [MAX_BITS-1:0] frame_data_q,
  output logic                out_bit_q,
  output logic                out_tick_q
);

  logic                sclk_d, en_n_d;
  logic [MAX_BITS-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;

  logic sclk_rise, en_fall, en_rise, shift_now, len_ok;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign en_fall   = ~en_n_s & en_n_d;
  assign en_rise   = en_n_s & ~en_n_d;
  assign shift_now = sclk_rise & ~en_n_s;

  assign len_ok = (cnt_q != '0) &&
                  (int'(cnt_q) <= MAX_BITS) &&
                  ((int'(cnt_q) % BYTE_W) == 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      en_n_d <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      en_n_d <= en_n_s;
    end
  end

  // Shift path: keeps the most recent MAX_BITS bits; the old MSB leaves as cascade data.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q       <= '0;
      out_bit_q  <= 1'b0;
      out_tick_q <= 1'b0;
    end else begin
      out_tick_q <= shift_now;
      if (shift_now) begin
        out_bit_q <= sh_q[MAX_BITS-1];
        sh_q      <= {sh_q[MAX_BITS-2:0], din_s};
      end
    end
  end

  // Saturating bit counter, cleared when a frame opens.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en_fall) begin
      cnt_q <= shift_now ? CNT_W'(1) : '0;
    end else if (shift_now && (cnt_q != '1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_done_q  <= 1'b0;
      frame_bytes_q <= '0;
      frame_data_q  <= '0;
    end else begin
      frame_done_q <= en_rise;
      if (en_rise) begin
        frame_bytes_q <= len_ok ? BC_W'(int'(cnt_q) / BYTE_W) : '0;
        frame_data_q  <= sh_q;
      end
    end
  end

  // R7: with the frame enable high nothing enters the shift path.
  a_r7_idle_no_shift: assert property (@(posedge clk) disable iff (rst)
    (en_n_s && en_n_d) |=> $stable(sh_q));

  // R6: a frame whose length is not whole bytes reports no bytes.
  a_r6_partial_byte: assert property (@(posedge clk) disable iff (rst)
    (en_rise && ((int'(cnt_q) % BYTE_W) != 0)) |=> (frame_bytes_q == '0));

  // R6: an overlong frame reports no bytes.
  a_r6_overlong: assert property (@(posedge clk) disable iff (rst)
    (en_rise && (int'(cnt_q) > MAX_BITS)) |=> (frame_bytes_q == '0));

endmodule

// File: rtl/sl_regbank.sv
module sl_regbank
  import sl_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int CFG_BYTES = 1,
  parameter int REF_BYTES = 2,
  parameter int DIV_BYTES = 3,
  localparam int MAX_BITS = BYTE_W * DIV_BYTES,
  localparam int BC_W     = $clog2(DIV_BYTES + 1),
  localparam int CFG_W    = BYTE_W * CFG_BYTES,
  localparam int REF_W    = BYTE_W * REF_BYTES,
  localparam int DIV_W    = BYTE_W * DIV_BYTES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_done,
  input  logic [BC_W-1:0]     frame_bytes,
  input  logic [MAX_BITS-1:0] frame_data,
  input  logic                div_load,
  input  logic                ref_load,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [REF_W-1:0]    ref_q,
  output logic [DIV_W-1:0]    div_q
);

  logic [REF_W-1:0] ref_stg_q;
  logic [DIV_W-1:0] div_stg_q;
  logic             ref_pend_q, div_pend_q;
  tgt_e             tgt;
  logic             commit;

  assign tgt    = frame_done ? pick_target(int'(frame_bytes), CFG_BYTES, REF_BYTES, DIV_BYTES)
                             : TGT_NONE;
  assign commit = div_pend_q & ~div_load & ~ref_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      ref_q      <= '0;
      div_q      <= '0;
      ref_stg_q  <= '0;
      div_stg_q  <= '0;
      ref_pend_q <= 1'b0;
      div_pend_q <= 1'b0;
    end else begin
      if (commit) begin
        div_q      <= div_stg_q;
        div_pend_q <= 1'b0;
        ref_pend_q <= 1'b0;
        if (ref_pend_q) ref_q <= ref_stg_q;
      end
      case (tgt)
        TGT_CFG: cfg_q <= frame_data[CFG_W-1:0];
        TGT_REF: begin
          ref_stg_q  <= frame_data[REF_W-1:0];
          ref_pend_q <= 1'b1;
        end
        TGT_DIV: begin
          div_stg_q  <= frame_data[DIV_W-1:0];
          div_pend_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R5: active ratios hold while either counter is reloading.
  a_r5_hold_while_loading: assert property (@(posedge clk) disable iff (rst)
    (div_load || ref_load) |=> ($stable(div_q) && $stable(ref_q)));

  // R3, R9: the active reference moves only with a commit that had a staged value.
  a_r3_ref_with_commit: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_q) |-> $past(div_pend_q && ref_pend_q));

  // R4: without a pending divider word nothing active moves.
  a_r4_idle_no_change: assert property (@(posedge clk) disable iff (rst)
    !div_pend_q |=> ($stable(div_q) && $stable(ref_q)));

  // R2: configuration changes only at the end of a frame.
  a_r2_cfg_only_on_frame: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(cfg_q));

endmodule

// File: rtl/serial_len_loader.sv
module serial_len_loader #(
  parameter int BYTE_W    = 8,
  parameter int CFG_BYTES = 1,
  parameter int REF_BYTES = 2,
  parameter int DIV_BYTES = 3,
  parameter int SYNC_LEN  = 2,
  localparam int CFG_W    = BYTE_W * CFG_BYTES,
  localparam int REF_W    = BYTE_W * REF_BYTES,
  localparam int DIV_W    = BYTE_W * DIV_BYTES,
  localparam int MAX_BITS = DIV_W,
  localparam int BC_W     = $clog2(DIV_BYTES + 1),
  localparam int CASC_BIT = CFG_W - 1,
  localparam int GP_BIT   = CFG_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             sdin,
  input  logic             sen_n,
  input  logic             div_load,
  input  logic             ref_load,
  output logic [CFG_W-1:0] cfg_o,
  output logic [REF_W-1:0] ref_o,
  output logic [DIV_W-1:0] div_o,
  output logic             dout
);

  logic [2:0]          pins_s;
  logic                frame_done;
  logic [BC_W-1:0]     frame_bytes;
  logic [MAX_BITS-1:0] frame_data;
  logic                out_bit, out_tick;
  logic                dout_q;

  sl_sync #(.W(3), .STAGES(SYNC_LEN), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sen_n, sclk, sdin}),
    .q   (pins_s)
  );

  sl_shifter #(.BYTE_W(BYTE_W), .MAX_BYTES(DIV_BYTES)) u_shift (
    .clk           (clk),
    .rst           (rst),
    .sclk_s        (pins_s[1]),
    .din_s         (pins_s[0]),
    .en_n_s        (pins_s[2]),
    .frame_done_q  (frame_done),
    .frame_bytes_q (frame_bytes),
    .frame_data_q  (frame_data),
    .out_bit_q     (out_bit),
    .out_tick_q    (out_tick)
  );

  sl_regbank #(
    .BYTE_W(BYTE_W), .CFG_BYTES(CFG_BYTES),
    .REF_BYTES(REF_BYTES), .DIV_BYTES(DIV_BYTES)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .frame_done  (frame_done),
    .frame_bytes (frame_bytes),
    .frame_data  (frame_data),
    .div_load    (div_load),
    .ref_load    (ref_load),
    .cfg_q       (cfg_o),
    .ref_q       (ref_o),
    .div_q       (div_o)
  );

  // Output pin: cascade data when enabled, otherwise a static level.
  always_ff @(posedge clk) begin
    if (rst)                   dout_q <= 1'b0;
    else if (!cfg_o[CASC_BIT]) dout_q <= cfg_o[GP_BIT];
    else if (out_tick)         dout_q <= out_bit;
  end

  assign dout = dout_q;

  // R8: in cascade mode the pin only moves on a shift.
  a_r8_cascade_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_o[CASC_BIT] && $past(cfg_o[CASC_BIT]) && !out_tick) |=> $stable(dout));

endmodule

// File: tb/serial_len_loader_bench.sv
module serial_len_loader_bench;

  localparam int CLK_P  = 10;
  localparam int HB     = 4;
  localparam int SETTLE = 12;

  logic clk = 1'b0;
  logic rst, sclk, sdin, sen_n, div_load, ref_load;
  logic [7:0]  cfg_o;
  logic [15:0] ref_o;
  logic [23:0] div_o;
  logic        dout;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  logic [7:0]  m_cfg;
  logic [15:0] m_ref, m_ref_stg;
  logic [23:0] m_div, m_div_stg;
  bit          m_ref_pend, m_div_pend;

  always #(CLK_P/2) clk = ~clk;

  serial_len_loader u_serial_len_loader (
    .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .sen_n(sen_n),
    .div_load(div_load), .ref_load(ref_load),
    .cfg_o(cfg_o), .ref_o(ref_o), .div_o(div_o), .dout(dout)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Bench model of the length decode and commit rules.
  function automatic void model_frame(input logic [31:0] data, input int nbits);
    if (nbits == 8) m_cfg = data[7:0];
    else if (nbits == 16) begin m_ref_stg = data[15:0]; m_ref_pend = 1; end
    else if (nbits == 24) begin m_div_stg = data[23:0]; m_div_pend = 1; end
  endfunction

  function automatic void model_commit();
    if (m_div_pend) begin
      m_div = m_div_stg;
      if (m_ref_pend) m_ref = m_ref_stg;
      m_div_pend = 0;
      m_ref_pend = 0;
    end
  endfunction

  task automatic send_frame(input logic [31:0] data, input int nbits);
    sen_n = 1'b0;
    tick(HB);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdin = data[i];
      tick(HB);
      sclk = 1'b1;
      tick(HB);
      sclk = 1'b0;
    end
    tick(HB);
    sen_n = 1'b1;
    tick(SETTLE);
    model_frame(data, nbits);
    if (!div_load && !ref_load) model_commit();
  endtask

  task automatic check_regs(input string req);
    check({req, " cfg"}, 32'(cfg_o), 32'(m_cfg));
    check({req, " ref"}, 32'(ref_o), 32'(m_ref));
    check({req, " div"}, 32'(div_o), 32'(m_div));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog: got 0x1 expected 0x0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; sclk = 1'b0; sdin = 1'b0; sen_n = 1'b1;
    div_load = 1'b0; ref_load = 1'b0;
    m_cfg = '0; m_ref = '0; m_ref_stg = '0; m_div = '0; m_div_stg = '0;
    m_ref_pend = 0; m_div_pend = 0;
    tick(5);
    rst = 1'b0;
    tick(2);

    // R1 reset state
    check_regs("R1");
    check("R1 dout", 32'(dout), 32'd0);

    // R2 one byte loads configuration; R8 static level from bit 6
    send_frame(32'h3C, 8);
    check_regs("R2");
    check("R8 level low", 32'(dout), 32'd0);
    send_frame(32'h40, 8);
    check("R8 level high", 32'(dout), 32'd1);

    // R3 reference alone only stages
    send_frame(32'h1234, 16);
    check("R3 ref staged only", 32'(ref_o), 32'd0);
    check_regs("R3");

    // R4 divider word commits with staged reference
    send_frame(32'hABCDEF, 24);
    check("R4 div", 32'(div_o), 32'hABCDEF);
    check("R4 ref together", 32'(ref_o), 32'h1234);

    // R9 divider commit without staged reference
    send_frame(32'h111111, 24);
    check("R9 ref kept", 32'(ref_o), 32'h1234);
    check_regs("R9");

    // R5 deferral by div_load
    div_load = 1'b1;
    send_frame(32'h0BEE, 16);
    send_frame(32'h654321, 24);
    tick(20);
    check("R5 div held", 32'(div_o), 32'h111111);
    check("R5 ref held", 32'(ref_o), 32'h1234);
    div_load = 1'b0;
    check("R5 same cycle", 32'(div_o), 32'h111111);
    tick(1);
    check("R5 one clock later div", 32'(div_o), 32'h654321);
    check("R5 one clock later ref", 32'(ref_o), 32'h0BEE);
    model_commit();

    // R5 deferral by ref_load
    ref_load = 1'b1;
    send_frame(32'h777777, 24);
    tick(10);
    check("R5 ref_load hold", 32'(div_o), 32'h654321);
    ref_load = 1'b0;
    tick(1);
    check("R5 ref_load release", 32'(div_o), 32'h777777);
    model_commit();

    // R6 malformed lengths; R8 cascade path on overlong frame
    send_frame(32'h80, 8);
    send_frame(32'h0, 0);
    check_regs("R6 zero");
    send_frame(32'h15, 5);
    check_regs("R6 five");
    send_frame(32'hFFF, 12);
    check_regs("R6 twelve");
    send_frame(32'hA5C30F69, 32);
    check_regs("R6 overlong");
    check("R8 cascade bit A", 32'(dout), 32'd1);
    send_frame(32'hA4C30F69, 32);
    check("R8 cascade bit B", 32'(dout), 32'd0);

    // R7 stray serial clocks with enable high
    send_frame(32'h00FFFF, 24);
    sdin = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick(HB); sclk = 1'b1; tick(HB); sclk = 1'b0;
    end
    tick(SETTLE);
    send_frame(32'h80, 8);
    check("R7 idle clocks ignored", 32'(dout), 32'd0);
    check_regs("R7");

    // Random mix of good and malformed frames
    for (int it = 0; it < 60; it++) begin
      int sel;
      int nb;
      logic [31:0] d;
      sel = int'($urandom % 6);
      d   = $urandom;
      case (sel)
        0: nb = 8;
        1: nb = 16;
        2, 3: nb = 24;
        4: nb = 1 + int'($urandom % 23);
        default: nb = 25 + int'($urandom % 8);
      endcase
      send_frame(d, nb);
      check_regs((nb % 8 == 0 && nb <= 24) ? "R4 random" : "R6 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule